// File: doc/BRIEF.md
# Decimated Control-Slot Frame Gate

This block sits on the receive side of a time-division-multiplexed serial codec port. The serial front end delivers one control word per frame. This gate decides, one frame at a time, whether that frame's control slot is honoured. When it is, the gate turns the control word into a one-cycle register-write strobe with an address and data.

A programmable skip count N thins out the honoured frames. Between two honoured frames there are N frames whose control content is discarded. N lives in a register that is written through this same gated path. After N is reprogrammed to a nonzero value, the first gap is one frame shorter than the gaps that follow. The `frame_live` output shows whether the current frame's control slot is being honoured.

Top module: `ctl_slot_gate`

## Requirements
- R1: After reset, N is 0, `frame_live` is low and `wr_en` stays low until the first `fsync`. The frame that the first `fsync` opens is live.
- R2: While N is 0, every frame is live.
- R3: In a live frame, the first `slot_stb` with a nonzero address raises `wr_en` for exactly one cycle, on the clock after the strobe. The control word is split as follows: `wr_addr` comes from `slot1_word[15:8]` and `wr_data` comes from `slot1_word[7:0]`.
- R4: A control word whose address field is 0x00 never raises `wr_en`.
- R5: In a frame that is not live, strobes raise no `wr_en`.
- R6: With a steady N, exactly N non-live frames fall between two consecutive live frames.
- R7: Writing a nonzero N in live frame W has this effect: frames W+1 to W+N-1 are not live and frame W+N is live. Writing N=1 makes W+1 live, and writing N=0 makes every following frame live. The skip register sits at address 0x11, and its value is the low 8 bits of the data field.
- R8: A write to the skip register appears on `wr_en` like any other write. It takes effect only at the next `fsync`, and the rest of the current frame stays live.
- R9: Only the first strobe of a frame is considered. Any later strobe in the same frame raises no `wr_en`, even when the first strobe had address 0.
- R10: A strobe in the same cycle as `fsync` is ignored.
- R11: `frame_live` changes only on the clock edge that samples `fsync` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | One-cycle frame-start pulse |
| slot_stb | input | 1 | Control word captured this cycle |
| slot1_word | input | 16 | Control word: address [15:8], data [7:0] |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Write address |
| wr_data | output | 8 | Write data |
| frame_live | output | 1 | Current frame's control slot is honoured |

## Verification
The bench reprograms N to 1, to 3 and back to 0, and then to random small values. It checks that the first gap is shortened and that later gaps are not. A design that reloads with N instead of N-1 shows one extra dead frame after each write of N. A design that applies N at once would drop the rest of the writing frame or shift every later live frame. The bench also sends zero-address words, duplicate strobes in one frame, and a strobe coinciding with `fsync`. A design that counts the wrong strobe or lets the frame edge leak through produces a stray `wr_en`.

// File: rtl/ctl_gate_pkg.sv
package ctl_gate_pkg;
    localparam int SLOT_W = 16;
    localparam int ADDR_W = 8;
    localparam int DATA_W = SLOT_W - ADDR_W;
    localparam int SKIP_W = 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ctl_word_t;
endpackage

// File: rtl/ctl_word_split.sv
module ctl_word_split
    import ctl_gate_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SKIP_ADDR = 8'h11
) (
    input  logic [SLOT_W-1:0] word,
    output ctl_word_t         fields,
    output logic              addr_nz,
    output logic              is_skip,
    output logic [SKIP_W-1:0] skip_val
);
    assign fields  = ctl_word_t'(word);
    assign addr_nz = (fields.addr != '0);
    assign is_skip = (fields.addr == SKIP_ADDR);

    generate
        if (SKIP_W <= DATA_W) begin : g_trunc
            assign skip_val = fields.data[SKIP_W-1:0];
        end else begin : g_ext
            assign skip_val = {{(SKIP_W-DATA_W){1'b0}}, fields.data};
        end
    endgenerate
endmodule

// File: rtl/frame_cadence.sv
module frame_cadence
    import ctl_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              skip_wr,
    input  logic [SKIP_W-1:0] skip_val,
    output logic              live
);
    typedef struct packed {
        logic [SKIP_W-1:0] skip;
        logic [SKIP_W-1:0] cnt;
        logic [SKIP_W-1:0] pval;
        logic              pend;
        logic              live;
    } cad_t;

    cad_t q, d;
    logic [SKIP_W-1:0] eff;
    logic [SKIP_W-1:0] nskip;

    always_comb begin
        d     = q;
        eff   = q.cnt;
        nskip = q.skip;
        if (skip_wr) begin
            d.pend = 1'b1;
            d.pval = skip_val;
        end
        if (fsync) begin
            if (q.pend) begin
                nskip = q.pval;
                eff   = (q.pval == '0) ? '0 : q.pval - 1'b1;
            end
            d.skip = nskip;
            d.pend = 1'b0;
            d.live = (eff == '0);
            d.cnt  = (eff == '0) ? nskip : eff - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign live = q.live;

    p_live_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync |=> $stable(q.live));
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= q.skip);
    p_zero_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && !q.pend && q.skip == '0) |=> q.live);
endmodule

// File: rtl/write_gate.sv
module write_gate
    import ctl_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              live,
    input  logic              stb,
    input  ctl_word_t         fields,
    input  logic              addr_nz,
    output logic              accept,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        logic              done;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } gate_t;

    gate_t q, d;
    logic  considered;

    always_comb begin
        considered = stb && !fsync && live && !q.done;
        accept     = considered && addr_nz;
        d          = q;
        d.wr       = accept;
        if (accept) begin
            d.addr = fields.addr;
            d.data = fields.data;
        end
        if (fsync)           d.done = 1'b0;
        else if (considered) d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_en   = q.wr;
    assign wr_addr = q.addr;
    assign wr_data = q.data;

    p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |=> !q.wr);
    p_addr_nz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |-> (q.addr != '0));
    p_live_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |-> $past(live));
    p_no_fsync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |-> !$past(fsync));
endmodule

// File: rtl/ctl_slot_gate.sv
module ctl_slot_gate
    import ctl_gate_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SKIP_ADDR = 8'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              slot_stb,
    input  logic [SLOT_W-1:0] slot1_word,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              frame_live
);
    ctl_word_t         fields;
    logic              addr_nz;
    logic              is_skip;
    logic [SKIP_W-1:0] skip_val;
    logic              accept;
    logic              live;

    ctl_word_split #(.SKIP_ADDR(SKIP_ADDR)) u_split (
        .word     (slot1_word),
        .fields   (fields),
        .addr_nz  (addr_nz),
        .is_skip  (is_skip),
        .skip_val (skip_val)
    );

    frame_cadence u_cad (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .skip_wr  (accept && is_skip),
        .skip_val (skip_val),
        .live     (live)
    );

    write_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync   (fsync),
        .live    (live),
        .stb     (slot_stb),
        .fields  (fields),
        .addr_nz (addr_nz),
        .accept  (accept),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    assign frame_live = live;
endmodule

// File: tb/sim_ctl_slot_gate.sv
module sim_ctl_slot_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic        slot_stb = 1'b0;
    logic [15:0] slot1_word = '0;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        frame_live;

    int total = 0;
    int bad = 0;

    // reference model state
    int m_n = 0, m_cnt = 0, m_pval = 0;
    bit m_pend = 0, m_live = 0, m_done = 0;

    localparam logic [7:0] SKIP_A = 8'h11;

    always #4 clk = ~clk;

    ctl_slot_gate u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .slot_stb(slot_stb),
        .slot1_word(slot1_word), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_live(frame_live)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff_gap();
        if (m_pend) return (m_pval == 0) ? 0 : m_pval - 1;
        return m_cnt;
    endfunction

    function automatic void model_fsync();
        int e;
        e = eff_gap();
        if (m_pend) m_n = m_pval;
        m_pend = 0;
        m_live = (e == 0);
        m_cnt  = (e == 0) ? m_n : e - 1;
        m_done = 0;
    endfunction

    function automatic bit model_strobe(input logic [15:0] w);
        bit ex;
        ex = m_live && !m_done && (w[15:8] != 0);
        if (m_live) m_done = 1;
        if (ex && w[15:8] == SKIP_A) begin
            m_pend = 1;
            m_pval = w[7:0];
        end
        return ex;
    endfunction

    task automatic strobe(input logic [15:0] w, input string req);
        bit ex;
        slot_stb = 1'b1; slot1_word = w;
        ex = model_strobe(w);
        step();
        slot_stb = 1'b0;
        check(wr_en == ex, req, wr_en, ex);
        if (ex) begin
            check(wr_addr == w[15:8], "R3 addr", wr_addr, w[15:8]);
            check(wr_data == w[7:0], "R3 data", wr_data, w[7:0]);
        end
        step();
        check(wr_en == 1'b0, "R3 pulse", wr_en, 0);
    endtask

    task automatic frame(input logic [15:0] w1, input bit second,
                         input logic [15:0] w2, input bit with_fs);
        string lreq;
        lreq = m_pend ? "R7" : (m_n == 0 ? "R2" : "R6");
        fsync = 1'b1;
        if (with_fs) begin slot_stb = 1'b1; slot1_word = 16'h0555; end
        model_fsync();
        step();
        fsync = 1'b0; slot_stb = 1'b0;
        check(frame_live == m_live, lreq, frame_live, m_live);
        if (with_fs) check(wr_en == 1'b0, "R10", wr_en, 0);
        step();
        strobe(w1, m_live ? "R3" : "R5");
        if (second) strobe(w2, "R9");
        step();
        check(frame_live == m_live, "R11/R8", frame_live, m_live);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (4) step();
        check(wr_en == 1'b0 && frame_live == 1'b0, "R1 reset", {wr_en, frame_live}, 0);
        rst_n = 1'b1;
        step();
        strobe(16'h0522, "R1 pre-frame");
        // directed: N = 0, live every frame
        frame(16'h0312, 0, '0, 0);
        check(frame_live == 1'b1, "R1 first frame", frame_live, 1);
        frame(16'h00AA, 0, '0, 0);                // R4
        frame(16'h0007, 1, 16'h0444, 0);          // R9 after addr zero
        frame(16'h0901, 1, 16'h0A02, 0);          // R9
        frame(16'h0B03, 0, '0, 1);                // R10
        // N = 3: shortened first gap
        frame({SKIP_A, 8'd3}, 0, '0, 0);          // R8
        repeat (10) frame(16'h2266, 0, '0, 0);    // R7 / R6
        // N = 1
        while (!m_live) frame(16'h2201, 0, '0, 0);
        frame({SKIP_A, 8'd1}, 0, '0, 0);
        repeat (6) frame(16'h3377, 0, '0, 0);
        // back to N = 0
        while (!m_live) frame(16'h2201, 0, '0, 0);
        frame({SKIP_A, 8'd0}, 0, '0, 0);
        repeat (4) frame(16'h4488, 0, '0, 0);
        // random
        for (int i = 0; i < 300; i++) begin
            logic [15:0] w1, w2;
            int sel;
            sel = $urandom_range(0, 9);
            w1 = 16'($urandom);
            if (sel == 0) w1[15:8] = 8'h00;
            else if (sel < 3) w1 = {SKIP_A, 8'($urandom_range(0, 4))};
            w2 = 16'($urandom);
            frame(w1, ($urandom_range(0, 4) == 0), w2, ($urandom_range(0, 9) == 0));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule